// File: doc/BRIEF.md
# Operand Bypass Selector

This block resolves read-after-write dependences for a five-stage in-order integer pipeline without stalling. Each cycle it takes the two source register numbers of the instruction now in execute. It compares them with the destination numbers of the two older instructions still in flight, one in the execute/memory register and one in the memory/writeback register. For each ALU input it chooses where the operand comes from: the register file read, the ALU result that has not yet been written back, or the value about to be written back.

The value about to be written back is either the ALU result or data returned by a load, picked by the writeback stage's load flag. This lets a load result reach a dependent instruction after one stall cycle, which is inserted elsewhere. The block is purely combinational. It contains the match comparators, the priority pickers and the two operand multiplexers, and it exposes both the selects and the chosen operands.

Top module: `fwd_bypass_unit`

## Requirements
- R1: When no in-flight destination matches a source, that operand's select is 2'b00 and the operand equals its register file value.
- R2: When the execute/memory stage has write enable set, a nonzero destination, and that destination equals a source, the select is 2'b10 and the operand equals the execute/memory ALU result.
- R3: When only the memory/writeback stage matches a source under the same conditions, the select is 2'b01 and the operand equals the writeback value.
- R4: When both stages match the same source, the execute/memory result is chosen (select 2'b10).
- R5: A destination of register 0 never causes forwarding, whatever the enables and sources are.
- R6: A stage whose write enable is clear never causes forwarding, even if its destination matches.
- R7: The selections for input A (from rs) and input B (from rt) are independent, so the two may differ in the same cycle.
- R8: The writeback value is the load data when the writeback load flag is 1, and the writeback ALU result when it is 0.
- R9: A select output never takes the value 2'b11. The operand multiplexer treats 2'b11 as the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | AW | Source register number for ALU input A |
| ex_rt_i | input | AW | Source register number for ALU input B |
| rf_a_i | input | DW | Register file value read for rs |
| rf_b_i | input | DW | Register file value read for rt |
| exm_wen_i | input | 1 | Execute/memory stage will write a register |
| exm_rd_i | input | AW | Execute/memory destination register |
| exm_alu_i | input | DW | Execute/memory ALU result |
| mwb_wen_i | input | 1 | Memory/writeback stage will write a register |
| mwb_rd_i | input | AW | Memory/writeback destination register |
| mwb_ld_i | input | 1 | Memory/writeback instruction is a load |
| mwb_alu_i | input | DW | Memory/writeback ALU result |
| mwb_load_i | input | DW | Memory/writeback load data |
| sel_a_o | output | 2 | Source select for input A |
| sel_b_o | output | 2 | Source select for input B |
| op_a_o | output | DW | Chosen operand A |
| op_b_o | output | DW | Chosen operand B |

## Verification
The bench targets the case where both stages hold the same destination. A design with the priority reversed would return the older writeback value and give a stale result. Register 0 is driven as a destination with its write enable set, and matching destinations are driven with the write enable clear. A design that omitted either guard would bypass values that are never written. The load flag is toggled under a writeback match to catch a design that passes the ALU result where loaded data belongs. Vectors with different sources for A and B expose any crossing of the two paths.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic          wen_i,
  input  logic [AW-1:0] rd_i,
  output logic          hit_o
);
  assign hit_o = wen_i && (rd_i != '0) && (rd_i == src_i);
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]      src_i,
  input  logic               exm_hit_i,
  input  logic               mwb_hit_i,
  output fwd_pkg::fwd_sel_e  sel_o
);
  import fwd_pkg::*;

  // younger result ranks first
  always_comb begin
    if (exm_hit_i)      sel_o = FWD_EXM;
    else if (mwb_hit_i) sel_o = FWD_MWB;
    else                sel_o = FWD_RF;
  end

  always_comb begin
    // R5
    zero_src_chk: assert (src_i != '0 || sel_o == FWD_RF);
  end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux #(
  parameter int DW = 32
) (
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] rf_i,
  input  logic [DW-1:0] exm_i,
  input  logic [DW-1:0] mwb_i,
  output logic [DW-1:0] op_o
);
  always_comb begin
    unique case (sel_i)
      2'b10:   op_o = exm_i;
      2'b01:   op_o = mwb_i;
      default: op_o = rf_i;
    endcase
  end
endmodule

// File: rtl/fwd_bypass_unit.sv
module fwd_bypass_unit #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] ex_rs_i,
  input  logic [AW-1:0] ex_rt_i,
  input  logic [DW-1:0] rf_a_i,
  input  logic [DW-1:0] rf_b_i,
  input  logic          exm_wen_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic [DW-1:0] exm_alu_i,
  input  logic          mwb_wen_i,
  input  logic [AW-1:0] mwb_rd_i,
  input  logic          mwb_ld_i,
  input  logic [DW-1:0] mwb_alu_i,
  input  logic [DW-1:0] mwb_load_i,
  output logic [1:0]    sel_a_o,
  output logic [1:0]    sel_b_o,
  output logic [DW-1:0] op_a_o,
  output logic [DW-1:0] op_b_o
);
  import fwd_pkg::*;

  localparam int NOPS = 2;

  logic [AW-1:0] src   [NOPS];
  logic [DW-1:0] rf_v  [NOPS];
  logic [1:0]    sel_v [NOPS];
  logic [DW-1:0] op_v  [NOPS];
  logic [DW-1:0] mwb_val;

  assign src[0]  = ex_rs_i;
  assign src[1]  = ex_rt_i;
  assign rf_v[0] = rf_a_i;
  assign rf_v[1] = rf_b_i;

  assign mwb_val = mwb_ld_i ? mwb_load_i : mwb_alu_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic     exm_hit, mwb_hit;
    fwd_sel_e sel;

    fwd_hit #(.AW(AW)) u_exm_hit (
      .src_i(src[g]), .wen_i(exm_wen_i), .rd_i(exm_rd_i), .hit_o(exm_hit)
    );
    fwd_hit #(.AW(AW)) u_mwb_hit (
      .src_i(src[g]), .wen_i(mwb_wen_i), .rd_i(mwb_rd_i), .hit_o(mwb_hit)
    );
    fwd_pick #(.AW(AW)) u_pick (
      .src_i(src[g]), .exm_hit_i(exm_hit), .mwb_hit_i(mwb_hit), .sel_o(sel)
    );
    assign sel_v[g] = sel;

    fwd_opmux #(.DW(DW)) u_mux (
      .sel_i(sel_v[g]), .rf_i(rf_v[g]), .exm_i(exm_alu_i),
      .mwb_i(mwb_val), .op_o(op_v[g])
    );

    always_comb begin
      // R4
      exm_first_chk: assert (!exm_hit || sel_v[g] == 2'b10);
      // R6
      no_wen_chk: assert (exm_wen_i || mwb_wen_i || sel_v[g] == 2'b00);
      // R9
      sel_legal_chk: assert (sel_v[g] != 2'b11);
      // R2
      exm_data_chk: assert (sel_v[g] != 2'b10 || op_v[g] == exm_alu_i);
    end
  end

  assign sel_a_o = sel_v[0];
  assign sel_b_o = sel_v[1];
  assign op_a_o  = op_v[0];
  assign op_b_o  = op_v[1];
endmodule

// File: tb/fwd_bypass_unit_tb.sv
module fwd_bypass_unit_tb;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NV = 12;
  localparam int VW = 27;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] ex_rs, ex_rt, exm_rd, mwb_rd;
  logic          exm_wen, mwb_wen, mwb_ld;
  logic [DW-1:0] rf_a, rf_b, exm_alu, mwb_alu, mwb_load;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] op_a, op_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  fwd_bypass_unit #(.AW(AW), .DW(DW)) u_dut (
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .rf_a_i(rf_a), .rf_b_i(rf_b),
    .exm_wen_i(exm_wen), .exm_rd_i(exm_rd), .exm_alu_i(exm_alu),
    .mwb_wen_i(mwb_wen), .mwb_rd_i(mwb_rd), .mwb_ld_i(mwb_ld),
    .mwb_alu_i(mwb_alu), .mwb_load_i(mwb_load),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .op_a_o(op_a), .op_b_o(op_b)
  );

  // {rs, rt, exm_wen, exm_rd, mwb_wen, mwb_rd, ld, exp_a, exp_b}
  localparam logic [VW-1:0] VEC [NV] = '{
    {5'd1,  5'd2,  1'b0, 5'd1,  1'b0, 5'd2,  1'b0, 2'b00, 2'b00},
    {5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  1'b0, 2'b10, 2'b00},
    {5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd4,  1'b0, 2'b00, 2'b01},
    {5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 5'd5,  1'b0, 2'b10, 2'b10},
    {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00},
    {5'd6,  5'd7,  1'b0, 5'd6,  1'b0, 5'd7,  1'b0, 2'b00, 2'b00},
    {5'd8,  5'd9,  1'b1, 5'd9,  1'b1, 5'd8,  1'b0, 2'b01, 2'b10},
    {5'd10, 5'd10, 1'b0, 5'd10, 1'b1, 5'd10, 1'b0, 2'b01, 2'b01},
    {5'd11, 5'd12, 1'b1, 5'd0,  1'b1, 5'd11, 1'b0, 2'b01, 2'b00},
    {5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd31, 1'b0, 2'b10, 2'b10},
    {5'd13, 5'd14, 1'b0, 5'd0,  1'b1, 5'd13, 1'b1, 2'b01, 2'b00},
    {5'd15, 5'd16, 1'b1, 5'd16, 1'b1, 5'd15, 1'b1, 2'b01, 2'b10}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7: return "R6";
      8: return "R5";
      9: return "R4";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
    if (exm_wen && exm_rd != 0 && exm_rd == s) return 2'b10;
    if (mwb_wen && mwb_rd != 0 && mwb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] ref_op(logic [1:0] s, logic [DW-1:0] rf);
    if (s == 2'b10) return exm_alu;
    if (s == 2'b01) return mwb_ld ? mwb_load : mwb_alu;
    return rf;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [1:0] ea, input logic [1:0] eb);
    logic [DW-1:0] xa, xb;
    xa = ref_op(ea, rf_a);
    xb = ref_op(eb, rf_b);
    chk(sel_a == ea, {tag, " sel_a"}, {30'd0, sel_a}, {30'd0, ea});
    chk(sel_b == eb, {tag, " sel_b"}, {30'd0, sel_b}, {30'd0, eb});
    chk(op_a == xa, {tag, " op_a"}, op_a, xa);
    chk(op_b == xb, {tag, " op_b"}, op_b, xb);
    // R9
    chk(sel_a != 2'b11 && sel_b != 2'b11, "R9 sel legal", {28'd0, sel_a, sel_b}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    ex_rs = '0; ex_rt = '0; exm_rd = '0; mwb_rd = '0;
    exm_wen = 1'b0; mwb_wen = 1'b0; mwb_ld = 1'b0;
    rf_a = 32'hA0A0_0001; rf_b = 32'hB0B0_0002; exm_alu = 32'hC1C1_0003;
    mwb_alu = 32'hD2D2_0004; mwb_load = 32'hE3E3_0005;
    @(negedge clk);
    check_all("R1 idle", 2'b00, 2'b00);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(posedge clk);
      {ex_rs, ex_rt, exm_wen, exm_rd, mwb_wen, mwb_rd, mwb_ld} = v[VW-1:4];
      @(negedge clk);
      check_all(vec_tag(i), v[3:2], v[1:0]);
    end

    // R8: same match, load flag toggled
    @(posedge clk);
    ex_rs = 5'd20; ex_rt = 5'd21; exm_wen = 1'b0; mwb_wen = 1'b1; mwb_rd = 5'd20; mwb_ld = 1'b0;
    @(negedge clk);
    chk(op_a == mwb_alu, "R8 alu path", op_a, mwb_alu);
    @(posedge clk);
    mwb_ld = 1'b1;
    @(negedge clk);
    chk(op_a == mwb_load, "R8 load path", op_a, mwb_load);

    // random stage contents vs reference priority (R2 R3 R4 R5 R6 R7)
    for (int n = 0; n < 400; n++) begin
      @(posedge clk);
      ex_rs   = 5'($urandom_range(0, 7));
      ex_rt   = 5'($urandom_range(0, 7));
      exm_rd  = 5'($urandom_range(0, 7));
      mwb_rd  = 5'($urandom_range(0, 7));
      exm_wen = 1'($urandom_range(0, 1));
      mwb_wen = 1'($urandom_range(0, 1));
      mwb_ld  = 1'($urandom_range(0, 1));
      rf_a = $urandom; rf_b = $urandom; exm_alu = $urandom;
      mwb_alu = $urandom; mwb_load = $urandom;
      @(negedge clk);
      check_all("R7 random", ref_sel(ex_rs), ref_sel(ex_rt));
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule